// File: doc/BRIEF.md
# Programmable Fractional Pixel Clock Divider

The block turns one of three free-running source clocks into a pixel clock for a display raster engine. A single 32-bit control word picks the source: a crystal input, or one of two PLL outputs. It then applies a pre-divider of 2, 2.5 or 3, or stops the clock, and follows that with an integer divide-by-N stage with N from 2 to 127. The half-integer ratio is made from flops on both edges of the selected source. The output period is therefore always a whole number of source half-periods.

Software reaches the control word over a small synchronous register port. The control word is protected by a one-shot key. A write to the lock register with the key value arms exactly one following write, and any other write disarms it. A new setting is taken over by the divider only while the output is low, and the divider counters then restart. This way a reprogramming or a source switch never cuts a high phase short. A combinational status output reports the programmed overall ratio in source half-periods, and an error flag marks an enabled word whose N is below 2.

Top module: `pixclk_gen`

## Requirements
- R1: After reset the control word reads 0, the lock register reads 0, clk_out is low, cfg_err is 0 and ratio_hp is 0.
- R2: With control bit 15 (enable) at 0, clk_out stays low whatever the other fields hold.
- R3: Control bit 14 at 0 selects xtal_clk whatever bit 13 holds; bit 14 at 1 selects pll_a_clk when bit 13 is 0 and pll_b_clk when bit 13 is 1.
- R4: Control bits 9:8 set the pre-divide ratio: 01 gives 2, 10 gives 2.5, 11 gives 3. The clk_out period is the source period times that ratio times N.
- R5: Pre-divide code 00 with enable at 1 holds clk_out low, keeps cfg_err at 0 and gives ratio_hp 0.
- R6: Control bits 6:0 hold N. Every value from 2 to 127 gives the period of R4, with a high time of floor(N/2) pre-divided periods.
- R7: With enable at 1 and N equal to 0 or 1, clk_out is held low and cfg_err is 1.
- R8: A write to address 0 (control) changes the control word only when the bus write just before it wrote 32'h0000_005A to address 1 (lock). Every bus write clears that arming, and address 1 reads back the arming state in bit 0.
- R9: Only bits 15, 14, 13, 9:8 and 6:0 of the control word are stored. All other bits read back as 0.
- R10: A new setting is adopted only while clk_out is low, so across reprogramming and source switches no high pulse is shorter than the shorter of the old and new high times.
- R11: ratio_hp equals N times 4, 5 or 6 for pre-divide codes 01, 10 and 11, and is 0 while the output is held inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register port clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 1 | 0 selects the control word, 1 the lock register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| xtal_clk | input | 1 | Crystal source clock |
| pll_a_clk | input | 1 | First PLL source clock |
| pll_b_clk | input | 1 | Second PLL source clock |
| clk_out | output | 1 | Divided pixel clock |
| cfg_err | output | 1 | Enabled control word carries N below 2 |
| ratio_hp | output | 10 | Programmed overall ratio in source half-periods |

## Verification
The bench times clk_out edges in real time for every pre-divide code and all three sources, with both values of the PLL bit under the crystal source, and for the whole N range from 2 to 127. It checks the period, the high time and the status together, so a 2.5 path that drops its negative-edge flop shows up as a period off by half a source cycle, and an off-by-one divider counter shows up as a period shifted by one pre-divided cycle. It drives the stop code, the disabled state and N of 0 and 1, where a design that ran anyway or missed the error flag would be caught. It also tries writes without the key, with a broken key sequence and after the key has been used, where a lock that stayed armed would let the control word change. Finally it reprograms and switches source while the output runs and records the narrowest high pulse; a design that took over the new setting mid-pulse would leave a runt below the smallest legal high time.

// File: rtl/pixclk_gen.sv
`timescale 1ns/1ps
module pixclk_gen #(
  parameter int          NW         = 7,
  parameter logic [31:0] UNLOCK_KEY = 32'h0000_005A
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic              bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              xtal_clk,
  input  logic              pll_a_clk,
  input  logic              pll_b_clk,
  output logic              clk_out,
  output logic              cfg_err,
  output logic [NW+2:0]     ratio_hp
);
  localparam int B_EN  = 15;
  localparam int B_EXT = 14;
  localparam int B_PLL = 13;
  localparam int B_PD  = 8;
  localparam int CW    = NW + 5;
  localparam logic [31:0] WMASK = (32'd1 << B_EN) | (32'd1 << B_EXT) | (32'd1 << B_PLL) |
                                  (32'd3 << B_PD) | ((32'd1 << NW) - 32'd1);

  function automatic logic [2:0] lim_of(input logic [1:0] pd);
    case (pd)
      2'b01:   return 3'd1;
      2'b10:   return 3'd4;
      2'b11:   return 3'd2;
      default: return 3'd0;
    endcase
  endfunction

  function automatic logic [2:0] half_of(input logic [1:0] pd);
    case (pd)
      2'b01:   return 3'd4;
      2'b10:   return 3'd5;
      2'b11:   return 3'd6;
      default: return 3'd0;
    endcase
  endfunction

  // register port
  logic [31:0] ctrl_q;
  logic        unlocked;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ctrl_q   <= '0;
      unlocked <= 1'b0;
    end else if (bus_we) begin
      unlocked <= bus_addr && (bus_wdata == UNLOCK_KEY);
      if (!bus_addr && unlocked) ctrl_q <= bus_wdata & WMASK;
    end

  assign bus_rdata = bus_addr ? {31'b0, unlocked} : ctrl_q;

  logic [1:0]    req_pd;
  logic [NW-1:0] req_n;
  logic          req_ok;
  assign req_pd   = ctrl_q[B_PD +: 2];
  assign req_n    = ctrl_q[NW-1:0];
  assign req_ok   = ctrl_q[B_EN] && (req_pd != 2'b00) && (req_n >= NW'(2));
  assign cfg_err  = ctrl_q[B_EN] && (req_n < NW'(2));
  assign ratio_hp = req_ok ? (NW+3)'(half_of(req_pd)) * (NW+3)'(req_n) : '0;

  // divider: active setting lives in the source domain
  logic [CW-1:0] req, act;
  logic [1:0]    act_pd;
  logic [NW-1:0] act_n;
  logic          act_ok;
  logic          sclk, pclk, chg;
  logic          clr, a_q, b_q, q;
  logic [2:0]    c, lim;
  logic [NW-1:0] cnt, cnt_nx;

  assign req    = {ctrl_q[B_EN], ctrl_q[B_EXT], ctrl_q[B_PLL], req_pd, req_n};
  assign act_pd = act[NW+1:NW];
  assign act_n  = act[NW-1:0];
  assign act_ok = act[CW-1] && (act_pd != 2'b00) && (act_n >= NW'(2));
  assign lim    = lim_of(act_pd);
  assign sclk   = !act[CW-2] ? xtal_clk : (act[CW-3] ? pll_b_clk : pll_a_clk);
  assign chg    = !q && (req != act);

  always_ff @(posedge sclk or negedge rst_n)
    if (!rst_n) begin
      act <= '0;
      clr <= 1'b1;
      c   <= '0;
      a_q <= 1'b0;
    end else begin
      if (chg) act <= req;
      clr <= chg || !act_ok;
      if (chg) begin
        c   <= '0;
        a_q <= 1'b0;
      end else if (clr) begin
        c   <= lim;
        a_q <= 1'b0;
      end else begin
        a_q <= (c == lim);
        c   <= (c == lim) ? 3'd0 : c + 3'd1;
      end
    end

  // negative-edge half of the 2.5 and 3 ratios
  always_ff @(negedge sclk or negedge rst_n)
    if (!rst_n) b_q <= 1'b0;
    else        b_q <= !clr && (((act_pd == 2'b10) && (c == 3'd2)) ||
                                ((act_pd == 2'b11) && (c == 3'd0)));

  assign pclk   = a_q | b_q;
  assign cnt_nx = (cnt == '0) ? act_n - NW'(1) : cnt - NW'(1);

  always_ff @(posedge pclk or posedge clr)
    if (clr) begin
      cnt <= '0;
      q   <= 1'b0;
    end else begin
      cnt <= cnt_nx;
      q   <= (cnt_nx >= act_n - (act_n >> 1));
    end

  assign clk_out = q;
endmodule

// File: rtl/pixclk_gen_chk.sv
`timescale 1ns/1ps
module pixclk_gen_chk #(
  parameter int          NW         = 7,
  parameter logic [31:0] UNLOCK_KEY = 32'h0000_005A
) (
  input logic           clk,
  input logic           rst_n,
  input logic           sclk,
  input logic           bus_we,
  input logic           bus_addr,
  input logic [31:0]    bus_wdata,
  input logic [31:0]    bus_rdata,
  input logic [31:0]    ctrl_q,
  input logic           unlocked,
  input logic [NW+4:0]  act,
  input logic           clk_out
);
  localparam logic [31:0] KEEP = (32'd7 << 13) | (32'd3 << 8) | ((32'd1 << NW) - 32'd1);

  logic act_ok;
  assign act_ok = act[NW+4] && (act[NW+1:NW] != 2'b00) && (act[NW-1:0] >= NW'(2));

  a_r8_locked_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !bus_addr && !unlocked) |=> $stable(ctrl_q));

  a_r8_key_single_use: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && !(bus_addr && bus_wdata == UNLOCK_KEY)) |=> !unlocked);

  a_r9_reserved_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_addr |-> ((bus_rdata & ~KEEP) == 32'd0));

  a_r10_adopt_in_low: assert property (@(posedge sclk) disable iff (!rst_n)
    !$stable(act) |-> !$past(clk_out));

  a_r2_idle_when_invalid: assert property (@(posedge sclk) disable iff (!rst_n)
    !act_ok |-> !clk_out);
endmodule

bind pixclk_gen pixclk_gen_chk #(.NW(NW), .UNLOCK_KEY(UNLOCK_KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .sclk(sclk), .bus_we(bus_we), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ctrl_q(ctrl_q), .unlocked(unlocked),
  .act(act), .clk_out(clk_out)
);

// File: tb/test_pixclk_gen.sv
`timescale 1ns/1ps
module test_pixclk_gen;
  localparam logic [31:0] KEY = 32'h0000_005A;

  logic        clk = 0, rst_n = 0, bus_we = 0, bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata;
  logic        xtal_clk = 0, pll_a_clk = 0, pll_b_clk = 0;
  logic        clk_out, cfg_err;
  logic [9:0]  ratio_hp;

  pixclk_gen i_pixclk_gen (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .xtal_clk(xtal_clk), .pll_a_clk(pll_a_clk), .pll_b_clk(pll_b_clk),
    .clk_out(clk_out), .cfg_err(cfg_err), .ratio_hp(ratio_hp)
  );

  always #10 clk = ~clk;
  always #8  xtal_clk = ~xtal_clk;
  always #5  pll_a_clk = ~pll_a_clk;
  always #6  pll_b_clk = ~pll_b_clk;

  int  n_vec = 0, n_bad = 0;
  real t_rise = 0.0, min_hi = 1.0e9;

  always @(posedge clk_out) t_rise = $realtime;
  always @(negedge clk_out) if ($realtime - t_rise < min_hi) min_hi = $realtime - t_rise;

  task automatic chk_i(string req, string what, longint got, longint exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  task automatic chk_r(string req, string what, real got, real exp);
    n_vec++;
    if (got - exp > 0.01 || exp - got > 0.01) begin
      n_bad++;
      $display("FAIL %s %s: got %0.3f expected %0.3f", req, what, got, exp);
    end
  endtask

  task automatic bus_wr(logic a, logic [31:0] d);
    @(negedge clk);
    bus_we = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 0; bus_addr = 0;
  endtask

  task automatic bus_rd(logic a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic prog(logic [31:0] d);
    bus_wr(1'b1, KEY);
    bus_wr(1'b0, d);
  endtask

  // src: 0 crystal, 1 PLL A, 2 PLL B, 3 crystal with PLL bit set
  function automatic logic [31:0] mk(int src, int pd, int n, bit en);
    logic [31:0] w;
    w = 32'(n) & 32'h7F;
    w |= 32'(pd & 3) << 8;
    if (en) w |= 32'h8000;
    if (src == 1 || src == 2) w |= 32'h4000;
    if (src == 2 || src == 3) w |= 32'h2000;
    return w;
  endfunction

  function automatic real src_per(int src);
    return (src == 1) ? 10.0 : (src == 2) ? 12.0 : 16.0;
  endfunction

  function automatic real pre_of(int pd);
    return (pd == 1) ? 2.0 : (pd == 2) ? 2.5 : 3.0;
  endfunction

  task automatic low_window(string req, int cycles);
    int seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (clk_out) seen++;
    end
    chk_i(req, "clk_out high samples in window", seen, 0);
  endtask

  task automatic t_reset;
    logic [31:0] d;
    bus_rd(1'b0, d);
    chk_i("R1", "control after reset", d, 0);
    bus_rd(1'b1, d);
    chk_i("R1", "lock after reset", d, 0);
    chk_i("R1", "cfg_err after reset", cfg_err, 0);
    chk_i("R1", "ratio_hp after reset", ratio_hp, 0);
    low_window("R1", 100);
  endtask

  task automatic t_lock;
    logic [31:0] d;
    bus_wr(1'b0, mk(1, 1, 4, 1));
    bus_rd(1'b0, d);
    chk_i("R8", "control after write without key", d, 0);
    low_window("R8", 50);
    bus_wr(1'b1, KEY);
    bus_wr(1'b1, 32'h0000_0033);
    bus_wr(1'b0, mk(1, 1, 4, 1));
    bus_rd(1'b0, d);
    chk_i("R8", "control after broken key sequence", d, 0);
    bus_wr(1'b1, KEY);
    bus_rd(1'b1, d);
    chk_i("R8", "lock register armed", d, 1);
    bus_wr(1'b0, 32'hFFFF_FFFF);
    bus_rd(1'b0, d);
    chk_i("R9", "all-ones write masked", d, 32'h0000_E37F);
    bus_rd(1'b1, d);
    chk_i("R8", "lock register disarmed after use", d, 0);
    bus_wr(1'b0, 32'h0);
    bus_rd(1'b0, d);
    chk_i("R8", "second write after one key", d, 32'h0000_E37F);
  endtask

  task automatic measure(string req, int src, int pd, int n);
    real ts, t0, th, tp, exp_p, exp_h;
    prog(mk(src, pd, n, 1));
    ts    = src_per(src);
    exp_p = ts * pre_of(pd) * n;
    exp_h = ts * pre_of(pd) * (n / 2);
    repeat (3) @(posedge clk_out);
    t0 = $realtime;
    @(negedge clk_out);
    th = $realtime - t0;
    @(posedge clk_out);
    tp = $realtime - t0;
    chk_r(req, $sformatf("period src%0d pd%0d N%0d", src, pd, n), tp, exp_p);
    chk_r("R6", $sformatf("high time src%0d pd%0d N%0d", src, pd, n), th, exp_h);
    chk_i("R11", $sformatf("ratio_hp pd%0d N%0d", pd, n), ratio_hp, (pd + 3) * n);
  endtask

  task automatic t_matrix;
    int ns[3] = '{2, 5, 127};
    for (int s = 0; s < 4; s++)
      for (int pd = 1; pd < 4; pd++)
        for (int k = 0; k < 3; k++)
          measure((s == 3) ? "R3" : "R4", s, pd, ns[k]);
  endtask

  task automatic t_sweep;
    for (int n = 2; n < 128; n++) measure("R6", 1, 1, n);
  endtask

  task automatic t_idle;
    prog(mk(1, 1, 4, 0));
    #8000;
    low_window("R2", 200);
    chk_i("R2", "cfg_err with enable 0", cfg_err, 0);
    chk_i("R11", "ratio_hp with enable 0", ratio_hp, 0);
    prog(mk(2, 0, 9, 1));
    #8000;
    low_window("R5", 200);
    chk_i("R5", "cfg_err with stop code", cfg_err, 0);
    chk_i("R5", "ratio_hp with stop code", ratio_hp, 0);
    prog(mk(0, 2, 1, 1));
    #8000;
    low_window("R7", 200);
    chk_i("R7", "cfg_err with N=1", cfg_err, 1);
    prog(mk(1, 3, 0, 1));
    #8000;
    low_window("R7", 200);
    chk_i("R7", "cfg_err with N=0", cfg_err, 1);
    measure("R7", 1, 3, 2);
    chk_i("R7", "cfg_err cleared by legal N", cfg_err, 0);
  endtask

  task automatic t_change;
    prog(mk(1, 1, 8, 1));
    repeat (3) @(posedge clk_out);
    @(negedge clk_out);
    min_hi = 1.0e9;
    prog(mk(0, 3, 5, 1));
    repeat (4) @(posedge clk_out);
    prog(mk(2, 2, 7, 1));
    repeat (4) @(posedge clk_out);
    prog(mk(1, 1, 8, 1));
    repeat (4) @(posedge clk_out);
    @(negedge clk_out);
    n_vec++;
    if (min_hi < 79.99) begin
      n_bad++;
      $display("FAIL R10 narrowest high pulse across reprogramming: got %0.3f expected >= 80.000", min_hi);
    end
    measure("R10", 1, 1, 8);
  endtask

  initial begin
    #3_000_000;
    n_bad++;
    $display("FAIL R4 watchdog expired waiting for clk_out: got 0 expected 1");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    t_reset();
    t_lock();
    t_matrix();
    t_sweep();
    t_idle();
    t_change();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule